// File: doc/BRIEF.md
# Flash Program Request Checker

This block sits between a CPU's flash control path and the flash programming engine. Every program or erase request is screened in the cycle it arrives. The screen covers three things: whether the data lies inside one 64-bit double-word, whether consecutive fast writes stay on one page, and whether the target is protected. For a program request it also checks whether the target double-word is still erased. Only a request that raises no error produces a one-cycle start pulse toward the engine. Any error detected instead lands in a sticky status register.

The status register also records completion and failure pulses coming back from the engine. It records each one only when its interrupt enable is on. Software clears each flag by writing a one to its bit. A second, independent path decides the fate of a write to the control register. Such a write either completes, is held with wait states while a configuration is busy, or is answered with a bus error while a suspended operation is still running.

Top module: `flash_req_checker`

## Requirements
- R1: A standard (non-fast) program request sets status bit 5 when its byte offset (address bits 2:0) plus its size in bytes (size code 0..3 = 1, 2, 4, 8 bytes) exceeds 8.
- R2: A fast program request sets status bit 5 when its page (address bits above bit 10) differs from the page of the last accepted fast request. The page record is forgotten after an engine completion or failure pulse and after any standard program request.
- R3: A program or erase request with the protection-hit input high sets status bit 4.
- R4: A program request sets status bit 3 when the current double-word is not all ones, unless the write data is all zeros.
- R5: An erase request ignores alignment and double-word content, so only bit 4 can result from it.
- R6: An engine failure pulse sets status bit 1 only when the error enable is 1.
- R7: An engine completion pulse sets status bit 0 only when the completion enable is 1.
- R8: A clear write with mask bits at 1 clears those status bits. Mask bits at 0 leave their flags unchanged. Bit 2 always reads 0.
- R9: When a hardware set and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: The start output pulses for one cycle, in the cycle after a request, only if that request raised no error.
- R11: A control write while config-busy is high and suspend is low sees ready low, no bus error, and leaves the control register unchanged.
- R12: A control write while suspend and op-active are both high sees bus error high and leaves the control register unchanged.
- R13: The control register resets to 0xC000_0000. A control write that is neither stalled nor faulted, including one made with suspend high and no operation active, loads the write data on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_fast | input | 1 | Program request is part of a fast sequence |
| req_addr | input | 17 | Byte address of the request |
| req_size | input | 2 | Write size code: 1, 2, 4 or 8 bytes |
| req_wdata | input | 64 | Double-word data being written |
| cur_dword | input | 64 | Present content of the target double-word |
| prot_hit | input | 1 | Address lies in a protected region |
| ien_err | input | 1 | Failure flag enable |
| ien_done | input | 1 | Completion flag enable |
| eng_done | input | 1 | Engine reports successful completion |
| eng_fail | input | 1 | Engine reports unsuccessful completion |
| clr_wr | input | 1 | Status clear write strobe |
| clr_mask | input | 6 | Write-one-to-clear mask for the status bits |
| eng_start | output | 1 | Start pulse for an accepted request |
| status | output | 6 | Sticky flags: 5 align, 4 protect, 3 program, 2 zero, 1 fail, 0 done |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| cfg_busy | input | 1 | Configuration busy |
| suspend | input | 1 | Program/erase suspend active |
| op_active | input | 1 | A program or erase is in progress |
| ctl_ready | output | 1 | Control write may complete this cycle |
| ctl_buserr | output | 1 | Control write is answered with a bus error |
| ctl_q | output | 32 | Control register contents |

## Verification
The hardest condition to reach from the ports is a page change inside a fast sequence. It needs an earlier accepted fast write to leave a page record behind, and it must happen without a completion pulse or a standard write erasing that record. The stimulus issues two accepted fast writes on one page and then a third on the next page. It clears the flags, sends a completion pulse with its enable off, and repeats the third write, which must now pass. The set-against-clear race is forced by raising a completion pulse and a clear of the same bit on one edge.

// File: rtl/fpec_pkg.sv
package fpec_pkg;
   localparam int ST_W     = 6;
   localparam int ST_ALIGN = 5;
   localparam int ST_PROT  = 4;
   localparam int ST_PROG  = 3;
   localparam int ST_RSVD  = 2;
   localparam int ST_FAIL  = 1;
   localparam int ST_DONE  = 0;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } wsize_e;
endpackage

// File: rtl/fpec_req_check.sv
module fpec_req_check #(
   parameter int ADDR_W   = 17,
   parameter int PAGE_LSB = 11,
   parameter int DATA_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_erase,
   input  logic              req_fast,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] cur_dword,
   input  logic              prot_hit,
   input  logic              seq_end,
   output logic              err_align,
   output logic              err_prot,
   output logic              err_prog,
   output logic              start_ok
);
   localparam int BYTES  = DATA_W / 8;
   localparam int OFS_W  = $clog2(BYTES);
   localparam int PAGE_W = ADDR_W - PAGE_LSB;

   if (PAGE_LSB <= OFS_W || PAGE_LSB >= ADDR_W) begin : g_bad_page
      $error("PAGE_LSB must lie between the double-word offset and ADDR_W");
   end
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data
      $error("DATA_W must be 32 or 64");
   end

   logic [4:0]        n_bytes;
   logic [4:0]        span;
   logic              std_misfit;
   logic              page_jump;
   logic [PAGE_W-1:0] cur_page;
   logic [PAGE_W-1:0] last_pg_q;
   logic              last_vld_q;
   logic              is_prog;

   assign is_prog    = req_valid && !req_erase;
   assign n_bytes    = 5'd1 << req_size;
   assign span       = 5'(req_addr[OFS_W-1:0]) + n_bytes;
   assign std_misfit = span > 5'(BYTES);
   assign cur_page   = req_addr[ADDR_W-1:PAGE_LSB];
   assign page_jump  = last_vld_q && (cur_page != last_pg_q);

   assign err_align = is_prog && (req_fast ? page_jump : std_misfit);
   assign err_prot  = req_valid && prot_hit;
   assign err_prog  = is_prog && (cur_dword != '1) && (req_wdata != '0);
   assign start_ok  = req_valid && !(err_align || err_prot || err_prog);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_vld_q <= 1'b0;
         last_pg_q  <= '0;
      end else if (is_prog && req_fast && start_ok) begin
         last_vld_q <= 1'b1;
         last_pg_q  <= cur_page;
      end else if (seq_end || (is_prog && !req_fast)) begin
         last_vld_q <= 1'b0;
      end
   end
endmodule

// File: rtl/fpec_status.sv
module fpec_status #(
   parameter int              W         = 6,
   parameter logic [W-1:0]    RSVD_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("status width must be positive");
   end

   for (genvar k = 0; k < W; k++) begin : g_bit
      if (RSVD_MASK[k]) begin : g_rsvd
         assign q[k] = 1'b0;
         p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            q[k] == 1'b0);
      end else begin : g_flag
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        f_q <= 1'b0;
            else if (set_i[k]) f_q <= 1'b1;
            else if (clr_i[k]) f_q <= 1'b0;
         end
         assign q[k] = f_q;
         p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> q[k]);
         p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !q[k]);
      end
   end
endmodule

// File: rtl/fpec_ctl_gate.sv
module fpec_ctl_gate #(
   parameter int             CTL_W   = 32,
   parameter logic [CTL_W-1:0] CTL_RST = 32'hC000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             cfg_busy,
   input  logic             suspend,
   input  logic             op_active,
   output logic             ctl_ready,
   output logic             ctl_buserr,
   output logic [CTL_W-1:0] ctl_q
);
   if (CTL_W < 1) begin : g_bad_w
      $error("control width must be positive");
   end

   logic fault, stall, accept;

   assign fault  = ctl_wr && suspend && op_active;
   assign stall  = ctl_wr && cfg_busy && !suspend;
   assign accept = ctl_wr && !fault && !stall;

   assign ctl_ready  = !stall;
   assign ctl_buserr = fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= CTL_RST;
      else if (accept) ctl_q <= ctl_wdata;
   end

   p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && cfg_busy && !suspend) |=> $stable(ctl_q));
   p_fault_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && suspend && op_active) |=> $stable(ctl_q));
   p_fault_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_buserr |-> ctl_ready);
endmodule

// File: rtl/flash_req_checker.sv
module flash_req_checker
   import fpec_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int PAGE_LSB = 11,
   parameter int DATA_W   = 64,
   parameter int CTL_W    = 32,
   parameter logic [CTL_W-1:0] CTL_RST = 32'hC000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_erase,
   input  logic              req_fast,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] cur_dword,
   input  logic              prot_hit,
   input  logic              ien_err,
   input  logic              ien_done,
   input  logic              eng_done,
   input  logic              eng_fail,
   input  logic              clr_wr,
   input  logic [ST_W-1:0]   clr_mask,
   output logic              eng_start,
   output logic [ST_W-1:0]   status,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              cfg_busy,
   input  logic              suspend,
   input  logic              op_active,
   output logic              ctl_ready,
   output logic              ctl_buserr,
   output logic [CTL_W-1:0]  ctl_q
);
   localparam logic [ST_W-1:0] RSVD = ST_W'(1) << ST_RSVD;

   logic            e_align, e_prot, e_prog, ok;
   logic [ST_W-1:0] st_set, st_clr;

   fpec_req_check #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .DATA_W(DATA_W)) u_chk (
      .clk, .rst_n, .req_valid, .req_erase, .req_fast, .req_addr, .req_size,
      .req_wdata, .cur_dword, .prot_hit,
      .seq_end   (eng_done || eng_fail),
      .err_align (e_align),
      .err_prot  (e_prot),
      .err_prog  (e_prog),
      .start_ok  (ok)
   );

   always_comb begin
      st_set           = '0;
      st_set[ST_ALIGN] = e_align;
      st_set[ST_PROT]  = e_prot;
      st_set[ST_PROG]  = e_prog;
      st_set[ST_FAIL]  = eng_fail && ien_err;
      st_set[ST_DONE]  = eng_done && ien_done;
   end
   assign st_clr = clr_wr ? clr_mask : '0;

   fpec_status #(.W(ST_W), .RSVD_MASK(RSVD)) u_st (
      .clk, .rst_n, .set_i(st_set), .clr_i(st_clr), .q(status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eng_start <= 1'b0;
      else        eng_start <= ok;
   end

   fpec_ctl_gate #(.CTL_W(CTL_W), .CTL_RST(CTL_RST)) u_ctl (
      .clk, .rst_n, .ctl_wr, .ctl_wdata, .cfg_busy, .suspend, .op_active,
      .ctl_ready, .ctl_buserr, .ctl_q
   );

   p_start_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> $past(req_valid));
   p_start_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !$past(e_align || e_prot || e_prog));
   p_done_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_DONE]) |-> $past(eng_done && ien_done));
   p_fail_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_FAIL]) |-> $past(eng_fail && ien_err));
endmodule

// File: tb/test_flash_req_checker.sv
module test_flash_req_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_erase = 0, req_fast = 0;
   logic [16:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_wdata = '0, cur_dword = '1;
   logic        prot_hit = 0, ien_err = 0, ien_done = 0, eng_done = 0, eng_fail = 0;
   logic        clr_wr = 0;
   logic [5:0]  clr_mask = '0;
   logic        eng_start;
   logic [5:0]  status;
   logic        ctl_wr = 0;
   logic [31:0] ctl_wdata = '0;
   logic        cfg_busy = 0, suspend = 0, op_active = 0;
   logic        ctl_ready, ctl_buserr;
   logic [31:0] ctl_q;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   flash_req_checker i_flash_req_checker (.*);

   function automatic logic [63:0] pat(input logic [1:0] s);
      case (s)
         2'd0:    return 64'h0;
         2'd1:    return '1;
         2'd2:    return 64'h0123_4567_89AB_CDEF;
         default: return 64'hFFFF_FFFF_FFFF_FFFE;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic req(input logic er, input logic fa, input logic [16:0] a,
                      input logic [1:0] sz, input logic [1:0] ws, input logic [1:0] cs,
                      input logic pr);
      @(negedge clk);
      req_valid = 1; req_erase = er; req_fast = fa; req_addr = a; req_size = sz;
      req_wdata = pat(ws); cur_dword = pat(cs); prot_hit = pr;
      @(negedge clk);
      req_valid = 0; prot_hit = 0;
   endtask

   task automatic clr(input logic [5:0] m);
      @(negedge clk); clr_wr = 1; clr_mask = m;
      @(negedge clk); clr_wr = 0; clr_mask = '0;
   endtask

   // {erase, fast, addr[16:0], size, wsel, csel, prot, exp_status[5:0], exp_start}
   localparam int NV = 12;
   localparam logic [32:0] TBL [NV] = '{
      {1'b0,1'b0,17'h00100,2'd3,2'd2,2'd1,1'b0,6'h00,1'b1}, // R1 aligned dword
      {1'b0,1'b0,17'h00104,2'd2,2'd2,2'd1,1'b0,6'h00,1'b1}, // R1 word at upper half
      {1'b0,1'b0,17'h00105,2'd2,2'd2,2'd1,1'b0,6'h20,1'b0}, // R1 word crossing
      {1'b0,1'b0,17'h00107,2'd0,2'd2,2'd1,1'b0,6'h00,1'b1}, // R1 last byte
      {1'b0,1'b0,17'h00106,2'd1,2'd2,2'd1,1'b0,6'h00,1'b1}, // R1 half at end
      {1'b0,1'b0,17'h00107,2'd1,2'd2,2'd1,1'b0,6'h20,1'b0}, // R1 half crossing
      {1'b0,1'b0,17'h00108,2'd3,2'd2,2'd3,1'b0,6'h08,1'b0}, // R4 not erased
      {1'b0,1'b0,17'h00108,2'd3,2'd0,2'd2,1'b0,6'h00,1'b1}, // R4 zero exemption
      {1'b0,1'b0,17'h00110,2'd3,2'd2,2'd1,1'b1,6'h10,1'b0}, // R3 protected program
      {1'b1,1'b0,17'h00800,2'd3,2'd2,2'd2,1'b1,6'h10,1'b0}, // R3 protected erase
      {1'b1,1'b0,17'h00103,2'd3,2'd2,2'd2,1'b0,6'h00,1'b1}, // R5 erase ignores rest
      {1'b0,1'b0,17'h00101,2'd3,2'd2,2'd2,1'b1,6'h38,1'b0}  // R1 R3 R4 together
   };

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R13 reset ctl", ctl_q, 32'hC000_0000);
      chk("R8 reset status", 32'(status), 0);
      chk("R10 reset start", 32'(eng_start), 0);
      rst_n = 1;

      for (int i = 0; i < NV; i++) begin
         logic [32:0] v;
         v = TBL[i];
         req(v[32], v[31], v[30:14], v[13:12], v[11:10], v[9:8], v[7]);
         chk($sformatf("R1/R3/R4/R5 vec%0d status", i), 32'(status), 32'(v[6:1]));
         chk($sformatf("R10 vec%0d start", i), 32'(eng_start), 32'(v[0]));
         clr(6'h3F);
      end

      // R2 fast page tracking
      req(0, 1, 17'h00800, 2'd3, 2'd2, 2'd1, 0);
      chk("R2 first fast", {status, eng_start}, 32'h01);
      req(0, 1, 17'h00808, 2'd3, 2'd2, 2'd1, 0);
      chk("R2 same page", {status, eng_start}, 32'h01);
      req(0, 1, 17'h01000, 2'd3, 2'd2, 2'd1, 0);
      chk("R2 page change", {status, eng_start}, {6'h20, 1'b0});
      clr(6'h3F);
      @(negedge clk); eng_done = 1;
      @(negedge clk); eng_done = 0;
      chk("R7 done gated off", 32'(status), 0);
      req(0, 1, 17'h01000, 2'd3, 2'd2, 2'd1, 0);
      chk("R2 after sequence end", {status, eng_start}, 32'h01);

      // R6 / R7 enables
      @(negedge clk); eng_fail = 1;
      @(negedge clk); eng_fail = 0;
      chk("R6 fail gated off", 32'(status), 0);
      ien_err = 1; ien_done = 1;
      @(negedge clk); eng_fail = 1; eng_done = 1;
      @(negedge clk); eng_fail = 0; eng_done = 0;
      chk("R6 R7 flags set", 32'(status), 32'h03);

      // R8 write-one-to-clear
      clr(6'h00);
      chk("R8 zero mask", 32'(status), 32'h03);
      clr(6'h04);
      chk("R8 reserved bit", 32'(status), 32'h03);
      clr(6'h02);
      chk("R8 clear one bit", 32'(status), 32'h01);

      // R9 set beats clear
      @(negedge clk); eng_done = 1; clr_wr = 1; clr_mask = 6'h01;
      @(negedge clk); eng_done = 0; clr_wr = 0; clr_mask = '0;
      chk("R9 set wins", 32'(status), 32'h01);
      clr(6'h01);
      chk("R8 cleared", 32'(status), 0);

      // R11 stall
      @(negedge clk); ctl_wr = 1; ctl_wdata = 32'h1234_5678; cfg_busy = 1;
      #1 chk("R11 ready low", {ctl_ready, ctl_buserr}, 32'h0);
      @(negedge clk);
      chk("R11 held", ctl_q, 32'hC000_0000);
      // R12 fault
      suspend = 1; op_active = 1;
      #1 chk("R12 bus error", {ctl_ready, ctl_buserr}, 32'h3);
      @(negedge clk);
      chk("R12 no update", ctl_q, 32'hC000_0000);
      // R13 suspended, idle: completes
      op_active = 0;
      #1 chk("R13 ready", {ctl_ready, ctl_buserr}, 32'h2);
      @(negedge clk);
      chk("R13 suspended idle write", ctl_q, 32'h1234_5678);
      suspend = 0; cfg_busy = 0; ctl_wdata = 32'h0000_00A5;
      @(negedge clk); ctl_wr = 0;
      chk("R13 plain write", ctl_q, 32'h0000_00A5);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule